// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the two-wire slave side of a 128-byte serial memory. It watches already-synchronised samples of the clock and data lines and finds the bus START and STOP conditions. It checks the control byte against its fixed device address and takes the byte after a write control byte as the word pointer. It then either streams memory bytes out to the master or collects incoming bytes in an eight-byte page buffer. It drives the data line only through a pull-down enable, which suits an open-drain pad.

The memory array itself is outside the block. The engine reads it through an asynchronous address/data port. When a write sequence ends with STOP, the engine hands the buffered page to a separate commit controller in one request. That controller runs the timed programming and applies the protection rules. It reports back a busy flag and a write-allowed flag. While busy is high the engine stays silent on the bus, so a master can poll with the device address until the engine acknowledges again.

Top module: `ser_mem_slave`

## Requirements
- R1: Only a control byte whose upper seven bits equal 1010000 is acknowledged. Bit 0 of the control byte is the direction: 1 reads and 0 writes. After any other address, SDA stays released for every clock until the next START.
- R2: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP. A START at any point, including in the middle of a byte, restarts reception of a control byte.
- R3: An acknowledge pulls SDA low from the SCL fall after the eighth bit to the SCL fall after the ninth bit. The pull-down never changes while SCL stays high.
- R4: While busy_i is high, no received byte is acknowledged, not even a matching control byte.
- R5: In a write, the low seven bits of the byte after the control byte are loaded into the address pointer. The bytes after that are acknowledged and stored.
- R6: Each stored byte goes to buffer slot pointer[2:0], and after it only the low three pointer bits advance. More than eight bytes wrap around and overwrite earlier slots. The byte count saturates at 8.
- R7: A STOP that ends a write with at least one data byte, while wr_allowed_i is high, raises commit_req_o for exactly one cycle. The request carries base = {pointer[6:3],000}, slot i in commit_data_o[8i+7:8i], a per-slot valid mask and the count. No request follows a STOP after only an address, or while wr_allowed_i is low.
- R8: A repeated START after the word address abandons the write but keeps the new pointer, so the following read starts there.
- R9: The pointer advances past every byte accessed, so a current-address read returns location n+1 after an access to location n.
- R10: In a read, a master ACK (SDA low on the ninth clock) sends the next byte. The pointer wraps from 7Fh to 00h.
- R11: After a master NACK the engine releases SDA and ignores the bus until the next START or STOP.
- R12: After reset SDA is released and no commit request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock sample |
| sda_i | input | 1 | Synchronised bus data sample |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| busy_i | input | 1 | Programming cycle in progress |
| wr_allowed_i | input | 1 | Protection policy permits a commit |
| mem_raddr_o | output | 7 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| commit_req_o | output | 1 | One-cycle page commit request |
| commit_base_o | output | 7 | Page base address of the commit |
| commit_data_o | output | 64 | Page buffer contents, slot 0 lowest |
| commit_mask_o | output | 8 | Slots that hold a received byte |
| commit_cnt_o | output | 4 | Number of received data bytes, saturated at 8 |

## Verification
A wrong pointer shows up on the next read byte: the master samples the wrong data within nine SCL clocks of the read's first data bit. A wrong state decision shows up one bit slot later as an acknowledge that is missing or extra. A faulty page buffer or slot index shows up in the one-cycle commit request, which the bench compares field by field within a few clocks of STOP. The bench also applies each commit to its memory model, so a corrupted byte is read back as wrong data in later phases.

// File: rtl/ser_mem_pkg.sv
package ser_mem_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CTRL  = 3'd1,
    S_WADDR = 3'd2,
    S_WDATA = 3'd3,
    S_RDATA = 3'd4,
    S_WAIT  = 3'd5
  } phase_t;
endpackage

// File: rtl/bus_edge_mon.sv
module bus_edge_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/pg_buffer.sv
module pg_buffer #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [W-1:0]       data_i,
  output logic [DEPTH*W-1:0] data_o,
  output logic [DEPTH-1:0]   mask_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] byte_q;
    logic         vld_q;
    logic         hit;
    assign hit = wr_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end
    end
    assign data_o[g*W +: W] = byte_q;
    assign mask_o[g]        = vld_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (wr_i && cnt_q != CNT_W'(DEPTH))
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_full_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH)) |-> (&mask_o));
endmodule

// File: rtl/ser_mem_slave.sv
module ser_mem_slave
  import ser_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ID     = 7'h50,
  parameter int         ADDR_W     = 7,
  parameter int         DATA_W     = 8,
  parameter int         PAGE_BYTES = 8,
  localparam int        IDX_W      = $clog2(PAGE_BYTES),
  localparam int        CNT_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_pull_o,
  input  logic                         busy_i,
  input  logic                         wr_allowed_i,
  output logic [ADDR_W-1:0]            mem_raddr_o,
  input  logic [DATA_W-1:0]            mem_rdata_i,
  output logic                         commit_req_o,
  output logic [ADDR_W-1:0]            commit_base_o,
  output logic [PAGE_BYTES*DATA_W-1:0] commit_data_o,
  output logic [PAGE_BYTES-1:0]        commit_mask_o,
  output logic [CNT_W-1:0]             commit_cnt_o
);
  localparam logic [3:0] LAST_BIT = 4'(DATA_W);

  logic scl_rise, scl_fall, start_det, stop_det;

  bus_edge_mon u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  phase_t              state_q, state_d;
  logic [3:0]          cnt_q, cnt_d;
  logic                in_ack_q, in_ack_d;
  logic                pull_q, pull_d;
  logic                mack_q, mack_d;
  logic                commit_q, commit_d;
  logic [DATA_W-1:0]   shreg_q, shreg_d;
  logic [DATA_W-1:0]   txsh_q, txsh_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic                buf_clr, buf_wr;
  logic                rx_phase, addr_hit, give_ack;
  logic [CNT_W-1:0]    buf_cnt;

  pg_buffer #(.DEPTH(PAGE_BYTES), .W(DATA_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .idx_i  (ptr_q[IDX_W-1:0]),
    .data_i (shreg_q),
    .data_o (commit_data_o),
    .mask_o (commit_mask_o),
    .cnt_o  (buf_cnt)
  );

  assign rx_phase = (state_q == S_CTRL) || (state_q == S_WADDR) || (state_q == S_WDATA);
  assign addr_hit = (shreg_q[DATA_W-1:1] == DEV_ID);
  assign give_ack = !busy_i && ((state_q != S_CTRL) || addr_hit);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    in_ack_d = in_ack_q;
    pull_d   = pull_q;
    mack_d   = mack_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    ptr_d    = ptr_q;
    commit_d = 1'b0;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    if (start_det) begin
      state_d  = S_CTRL;
      cnt_d    = '0;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
    end else if (stop_det) begin
      if (state_q == S_WDATA && buf_cnt != '0 && wr_allowed_i) commit_d = 1'b1;
      state_d  = S_IDLE;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
    end else if (rx_phase) begin
      if (!in_ack_q) begin
        if (scl_rise && cnt_q != LAST_BIT) begin
          shreg_d = {shreg_q[DATA_W-2:0], sda_i};
          cnt_d   = cnt_q + 4'd1;
        end else if (scl_fall && cnt_q == LAST_BIT) begin
          cnt_d    = '0;
          in_ack_d = give_ack;
          pull_d   = give_ack;
          if (!give_ack) begin
            state_d = S_WAIT;
          end else begin
            case (state_q)
              S_CTRL:  state_d = shreg_q[0] ? S_RDATA : S_WADDR;
              S_WADDR: begin
                ptr_d   = shreg_q[ADDR_W-1:0];
                buf_clr = 1'b1;
                state_d = S_WDATA;
              end
              default: begin
                buf_wr = 1'b1;
                ptr_d  = {ptr_q[ADDR_W-1:IDX_W], ptr_q[IDX_W-1:0] + IDX_W'(1)};
              end
            endcase
          end
        end
      end else if (scl_fall) begin
        in_ack_d = 1'b0;
        pull_d   = 1'b0;
      end
    end else if (state_q == S_RDATA) begin
      if (in_ack_q) begin
        if (scl_rise && !pull_q) mack_d = sda_i;
        if (scl_fall) begin
          in_ack_d = 1'b0;
          if (pull_q || !mack_q) begin
            txsh_d = mem_rdata_i;
            ptr_d  = ptr_q + ADDR_W'(1);
            pull_d = !mem_rdata_i[DATA_W-1];
            cnt_d  = '0;
          end else begin
            pull_d  = 1'b0;
            state_d = S_WAIT;
          end
        end
      end else begin
        if (scl_rise) cnt_d = cnt_q + 4'd1;
        if (scl_fall) begin
          if (cnt_q == LAST_BIT) begin
            pull_d   = 1'b0;
            in_ack_d = 1'b1;
            mack_d   = 1'b1;
          end else begin
            txsh_d = {txsh_q[DATA_W-2:0], 1'b0};
            pull_d = !txsh_q[DATA_W-2];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b1;
      commit_q <= 1'b0;
      shreg_q  <= '0;
      txsh_q   <= '0;
      ptr_q    <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      in_ack_q <= in_ack_d;
      pull_q   <= pull_d;
      mack_q   <= mack_d;
      commit_q <= commit_d;
      shreg_q  <= shreg_d;
      txsh_q   <= txsh_d;
      ptr_q    <= ptr_d;
    end
  end

  assign sda_pull_o    = pull_q;
  assign mem_raddr_o   = ptr_q;
  assign commit_req_o  = commit_q;
  assign commit_base_o = {ptr_q[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  assign commit_cnt_o  = buf_cnt;

  p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req_o |=> !commit_req_o);

  p_commit_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req_o |-> (commit_mask_o != '0));

  p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rx_phase && !in_ack_q && scl_fall && cnt_q == LAST_BIT && !start_det && !stop_det)
      |=> !sda_pull_o);

  p_steady_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_det || stop_det)) |-> $stable(sda_pull_o));

  p_pull_in_session_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state_q != S_IDLE && state_q != S_WAIT));
endmodule

// File: tb/ser_mem_slave_tb_top.sv
module ser_mem_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic wr_ok = 1'b1;
  logic sda_pull, commit_req;
  logic [6:0] raddr, c_base;
  logic [7:0] rdata, c_mask;
  logic [63:0] c_data;
  logic [3:0] c_cnt;
  wire sda_line = m_sda & ~sda_pull;

  logic [7:0] mem [128];
  logic [7:0] wb [16];
  logic [7:0] e_pg [8];
  logic [7:0] e_mask;
  logic [3:0] e_cnt;
  logic [6:0] e_base;
  int exp_ptr = 0;
  bit exp_commit = 0;
  bit got_commit = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign rdata = mem[raddr];

  ser_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .busy_i(busy), .wr_allowed_i(wr_ok), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .commit_req_o(commit_req), .commit_base_o(c_base), .commit_data_o(c_data),
    .commit_mask_o(c_mask), .commit_cnt_o(c_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // commit model: compared on every clock
  always @(negedge clk) begin
    if (rst_n && commit_req) begin
      chk(exp_commit && !got_commit, "R7 unexpected commit", 1, 0);
      got_commit = 1;
      chk(c_base == e_base, "R7 base", c_base, e_base);
      chk(c_mask == e_mask, "R6 mask", c_mask, e_mask);
      chk(c_cnt == e_cnt, "R6 count", c_cnt, e_cnt);
      for (int k = 0; k < 8; k++) begin
        if (e_mask[k]) chk(c_data[8*k +: 8] == e_pg[k], "R6 slot data", c_data[8*k +: 8], e_pg[k]);
        if (c_mask[k]) mem[c_base + 7'(k)] = c_data[8*k +: 8];
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b, output logic obs);
    m_sda = b;
    wait_n(3);
    scl = 1'b1;
    wait_n(2);
    obs = sda_line;
    wait_n(2);
    scl = 1'b0;
    wait_n(2);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wait_n(2);
    scl = 1'b1;   wait_n(3);
    m_sda = 1'b0; wait_n(3);
    scl = 1'b0;   wait_n(2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wait_n(2);
    scl = 1'b1;   wait_n(3);
    m_sda = 1'b1; wait_n(3);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit want_ack, input string tag);
    logic o;
    for (int i = 7; i >= 0; i--) tx_bit(b[i], o);
    tx_bit(1'b1, o);
    chk(o == !want_ack, tag, o, !want_ack);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic o;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tx_bit(1'b1, o);
      b = {b[6:0], o};
    end
    tx_bit(nack, o);
  endtask

  task automatic set_ptr(input logic [6:0] a, input string tag);
    do_start();
    send_byte(8'hA0, 1, tag);
    send_byte({1'b0, a}, 1, tag);
    exp_ptr = a;
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic [7:0] b;
    do_start();
    send_byte(8'hA1, 1, tag);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i == n - 1));
      chk(b == mem[exp_ptr], tag, b, mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 128;
    end
  endtask

  task automatic wr_seq(input logic [6:0] a, input int n, input string tag);
    set_ptr(a, tag);
    e_mask = '0;
    for (int i = 0; i < n; i++) begin
      send_byte(wb[i], 1, tag);
      e_pg[(a + i) % 8] = wb[i];
      e_mask[(a + i) % 8] = 1'b1;
    end
    e_cnt = 4'((n > 8) ? 8 : n);
    e_base = {a[6:3], 3'b000};
    exp_ptr = {a[6:3], 3'((a + n) % 8)};
    exp_commit = (n > 0) && wr_ok;
    got_commit = 0;
    do_stop();
    wait_n(6);
    if (exp_commit) chk(got_commit, "R7 commit missing", got_commit, 1);
    exp_commit = 0;
  endtask

  initial begin
    logic o;
    logic [7:0] b;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
    wait_n(3);
    chk(sda_pull == 1'b0, "R12 sda released in reset", sda_pull, 0);
    rst_n = 1'b1;
    wait_n(3);
    chk(sda_pull == 1'b0 && commit_req == 1'b0, "R12 idle after reset", {sda_pull, commit_req}, 0);

    // byte write of three bytes, then random read and current read
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
    wr_seq(7'h10, 3, "R5 write");
    set_ptr(7'h11, "R8 set pointer");
    rd_cur(1, "R8 random read");
    tx_bit(1'b1, o);
    chk(o == 1'b1, "R11 released after NACK", o, 1);
    do_stop();
    rd_cur(1, "R9 current address read");
    do_stop();

    // sequential read across the top of the array
    set_ptr(7'h7E, "R10 set pointer");
    rd_cur(4, "R10 sequential wrap");
    do_stop();

    // foreign addresses
    do_start();
    send_byte(8'hA2, 0, "R1 foreign address");
    send_byte(8'h00, 0, "R1 silent after foreign");
    do_stop();
    do_start();
    send_byte(8'h20, 0, "R1 other address");
    do_stop();

    // busy: no acknowledge, then polling succeeds
    busy = 1'b1;
    do_start();
    send_byte(8'hA0, 0, "R4 busy no ack");
    do_stop();
    busy = 1'b0;
    do_start();
    send_byte(8'hA0, 1, "R4 ack after busy");
    do_stop();

    // page wrap with ten bytes
    for (int i = 0; i < 10; i++) wb[i] = 8'(8'hC0 + i);
    wr_seq(7'h25, 10, "R6 page wrap");
    rd_cur(1, "R6 pointer after wrap");
    do_stop();
    chk(mem[7'h27] == 8'hC2, "R6 memory slot 7", mem[7'h27], 8'hC2);

    // address only, no commit; pointer still loaded
    wr_seq(7'h40, 0, "R7 address only");
    rd_cur(1, "R7 pointer from address only");
    do_stop();

    // protection denies commit
    wr_ok = 1'b0;
    wb[0] = 8'hEE; wb[1] = 8'hDD;
    wr_seq(7'h50, 2, "R7 denied");
    wr_ok = 1'b1;
    set_ptr(7'h50, "R7 denied set");
    rd_cur(2, "R7 memory unchanged");
    do_stop();

    // START in the middle of a byte
    do_start();
    tx_bit(1'b1, o); tx_bit(1'b0, o); tx_bit(1'b1, o);
    do_start();
    send_byte(8'hA1, 1, "R2 restart mid byte");
    recv_byte(b, 1'b1);
    chk(b == mem[exp_ptr], "R2 data after restart", b, mem[exp_ptr]);
    exp_ptr = (exp_ptr + 1) % 128;
    do_stop();

    wait_n(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule